// File: doc/BRIEF.md
# HC-128 Keystream Generator with Banked Tables

This block produces the HC-128 keystream, one 32-bit word per clock once it is running. It keeps the two 512-word secret tables, called P and Q here, in on-chip RAM. Each table is interleaved across `NBANK` single-write banks by the low address bits, so the five table reads and the one table write of every update step are served in a single cycle. The default is two banks, split by address parity. Four banks are also supported.

Key and IV expansion are not part of this block. Software or a neighbouring block writes the already-initialised tables through the load port while the generator is idle. A one-cycle `start` pulse then launches the keystream. Steps 0 to 511 of each 1024-step round update P, and steps 512 to 1023 update Q. Each step's word leaves a four-stage pipeline made of the read, update, lookup and output registers.

Top module: `hc128_keystream`

## Requirements
- R1: While `rst` is high at a rising edge, `ks_valid` and `ks_word` are both 0 after that edge.
- R2: While the generator is idle, `load_en` writes `load_data` into word `load_addr` of table P when `load_tsel`=0, or of table Q when `load_tsel`=1.
- R3: `ks_valid` stays low until the third rising edge after the edge that samples `start` high, and it is high after that edge.
- R4: Once `ks_valid` is high, it stays high on every cycle until reset, and a new word appears on every cycle.
- R5: Step n with (n mod 1024) < 512 uses j = n mod 512. It sets P[j] += g1(P[j-3], P[j-10], P[j-511]), where g1(x,y,z) = (rotr(x,10) ^ rotr(z,23)) + rotr(y,8). It outputs (Q[b0] + Q[256+b2]) ^ P[j], with b0 and b2 taken from bits 7:0 and 23:16 of P[j-12]. Indices wrap mod 512, sums wrap mod 2^32, and reads see every earlier step's write.
- R6: Step n with (n mod 1024) >= 512 mirrors R5 with the tables swapped and g2(x,y,z) = (rotl(x,10) ^ rotl(z,23)) + rotl(y,8).
- R7: After step 1023 the step count wraps to 0 and P is updated again from its current contents.
- R8: The stream does not depend on `NBANK` (2 or 4).
- R9: A `start` pulse while the generator is running neither restarts nor disturbs the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches keystream generation from step 0 |
| load_en | input | 1 | Table preload write strobe, honoured while idle |
| load_tsel | input | 1 | Preload target: 0 selects P, 1 selects Q |
| load_addr | input | 9 | Preload word address |
| load_data | input | 32 | Preload word |
| ks_valid | output | 1 | Keystream word valid |
| ks_word | output | 32 | Keystream word |

## Verification
Two things can fall in the same cycle. One is the write-back of step n into the active table. The other is a read of that table by a later step still in the pipeline: a step-read three steps behind, or a lookup into the table that starts being updated at a phase boundary. Long runs that cross both the 512 and the 1024 step boundaries provoke this on every cycle, with both random and patterned tables. A bench reference model that updates strictly in order judges every word. The same stimulus drives a two-bank and a four-bank instance, and their streams must match word for word.

// File: rtl/hc128_ks_pkg.sv
package hc128_ks_pkg;
  localparam int WORD_W    = 32;
  localparam int TBL_DEPTH = 512;
  localparam int TAW       = $clog2(TBL_DEPTH);
  localparam int STW       = TAW + 1;
  localparam int NRD       = 7;
  // read port roles
  localparam int RP_J   = 0;
  localparam int RP_M3  = 1;
  localparam int RP_M10 = 2;
  localparam int RP_M511 = 3;
  localparam int RP_M12 = 4;
  localparam int RP_LO  = 5;
  localparam int RP_HI  = 6;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t mix_fwd(word_t x, word_t y, word_t z);
    return (rotr(x, 10) ^ rotr(z, 23)) + rotr(y, 8);
  endfunction

  function automatic word_t mix_rev(word_t x, word_t y, word_t z);
    return (rotr(x, WORD_W - 10) ^ rotr(z, WORD_W - 23)) + rotr(y, WORD_W - 8);
  endfunction
endpackage

// File: rtl/hc128_ks_bank.sv
module hc128_ks_bank import hc128_ks_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int RDP   = NRD,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           wa,
  input  word_t                   wd,
  input  logic [RDP-1:0][AW-1:0]  ra,
  output word_t [RDP-1:0]         rd
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // synchronous read-first ports
  always_ff @(posedge clk) begin
    for (int k = 0; k < RDP; k++) rd[k] <= mem[ra[k]];
  end
endmodule

// File: rtl/hc128_ks_table.sv
module hc128_ks_table import hc128_ks_pkg::*; #(
  parameter int NBANK = 2
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [TAW-1:0]         wa,
  input  word_t                  wd,
  input  logic [NRD-1:0][TAW-1:0] ra,
  output word_t [NRD-1:0]        rd
);
  localparam int LB     = $clog2(NBANK);
  localparam int BAW    = TAW - LB;
  localparam int BDEPTH = TBL_DEPTH / NBANK;

  logic [NRD-1:0][BAW-1:0] bra;
  logic [NRD-1:0][LB-1:0]  sel_q;
  word_t [NRD-1:0]         brd [NBANK];
  logic [NBANK-1:0]        bwe;

  always_comb begin
    for (int k = 0; k < NRD; k++) bra[k] = ra[k][TAW-1:LB];
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NRD; k++) sel_q[k] <= ra[k][LB-1:0];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bwe[b] = we && (wa[LB-1:0] == LB'(b));
    hc128_ks_bank #(.DEPTH(BDEPTH), .RDP(NRD)) u_bank (
      .clk (clk),
      .we  (bwe[b]),
      .wa  (wa[TAW-1:LB]),
      .wd  (wd),
      .ra  (bra),
      .rd  (brd[b])
    );
  end

  always_comb begin
    for (int k = 0; k < NRD; k++) rd[k] = brd[sel_q[k]][k];
  end
endmodule

// File: rtl/hc128_keystream.sv
module hc128_keystream import hc128_ks_pkg::*; #(
  parameter int NBANK = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              load_en,
  input  logic              load_tsel,
  input  logic [TAW-1:0]    load_addr,
  input  logic [WORD_W-1:0] load_data,
  output logic              ks_valid,
  output logic [WORD_W-1:0] ks_word
);
  logic           running;
  logic [STW-1:0] step;
  logic           ph_a;
  logic [TAW-1:0] j_a;

  logic           v_b, ph_b, v_c, ph_c;
  logic [TAW-1:0] j_b;
  word_t          new_c;

  logic [NRD-1:0][TAW-1:0] rda;
  word_t [NRD-1:0] p_rd, q_rd, act;
  word_t           new_b, look, hsum;

  logic           p_we, q_we, ld_p, ld_q;
  logic [TAW-1:0] p_wa, q_wa;
  word_t          p_wd, q_wd;

  assign ph_a = step[TAW];
  assign j_a  = step[TAW-1:0];

  // step counter and run flag
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      step    <= '0;
    end else if (!running) begin
      running <= start;
      step    <= '0;
    end else begin
      step <= step + 1'b1;
    end
  end

  // stage A: five step reads, identical on both tables
  always_comb begin
    rda[RP_J]    = j_a;
    rda[RP_M3]   = j_a - TAW'(3);
    rda[RP_M10]  = j_a - TAW'(10);
    rda[RP_M511] = j_a - TAW'(511);
    rda[RP_M12]  = j_a - TAW'(12);
    // stage B: lookups into the other table
    rda[RP_LO]   = {1'b0, look[7:0]};
    rda[RP_HI]   = {1'b1, look[23:16]};
  end

  // stage B: update of the active table word
  always_comb begin
    act   = ph_b ? q_rd : p_rd;
    new_b = act[RP_J] + (ph_b ? mix_rev(act[RP_M3], act[RP_M10], act[RP_M511])
                              : mix_fwd(act[RP_M3], act[RP_M10], act[RP_M511]));
    look  = act[RP_M12];
    hsum  = ph_c ? (p_rd[RP_LO] + p_rd[RP_HI]) : (q_rd[RP_LO] + q_rd[RP_HI]);
  end

  // write-back has priority; preload only while idle
  always_comb begin
    ld_p = load_en && !running && !load_tsel;
    ld_q = load_en && !running &&  load_tsel;
    p_we = (v_b && !ph_b) || ld_p;
    q_we = (v_b &&  ph_b) || ld_q;
    p_wa = v_b ? j_b : load_addr;
    q_wa = v_b ? j_b : load_addr;
    p_wd = v_b ? new_b : load_data;
    q_wd = v_b ? new_b : load_data;
  end

  hc128_ks_table #(.NBANK(NBANK)) u_ptbl (
    .clk(clk), .we(p_we), .wa(p_wa), .wd(p_wd), .ra(rda), .rd(p_rd)
  );
  hc128_ks_table #(.NBANK(NBANK)) u_qtbl (
    .clk(clk), .we(q_we), .wa(q_wa), .wd(q_wd), .ra(rda), .rd(q_rd)
  );

  // pipeline registers
  always_ff @(posedge clk) begin
    if (rst) begin
      v_b      <= 1'b0;
      v_c      <= 1'b0;
      ks_valid <= 1'b0;
      ks_word  <= '0;
    end else begin
      v_b      <= running;
      v_c      <= v_b;
      ks_valid <= v_c;
      if (v_c) ks_word <= hsum ^ new_c;
    end
  end

  always_ff @(posedge clk) begin
    ph_b  <= ph_a;
    j_b   <= j_a;
    ph_c  <= ph_b;
    new_c <= new_b;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!ks_valid && ks_word == '0));
  // R3
  first_word_lat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> ##3 $rose(ks_valid));
  // R4
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ks_valid |=> ks_valid);
  // R7
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (running && step == '1) |=> (step == '0));
  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (running && start) |=> (running && step == $past(step) + 1'b1));
endmodule

// File: tb/hc128_keystream_bench.sv
module hc128_keystream_bench;
  logic        clk = 1'b0;
  logic        rst, start, load_en, load_tsel;
  logic [8:0]  load_addr;
  logic [31:0] load_data;
  logic        v2, v4;
  logic [31:0] w2, w4;

  int nchk = 0;
  int nerr = 0;

  logic [31:0] mp [512];
  logic [31:0] mq [512];

  always #5 clk = ~clk;

  hc128_keystream u_hc128_keystream (
    .clk(clk), .rst(rst), .start(start), .load_en(load_en), .load_tsel(load_tsel),
    .load_addr(load_addr), .load_data(load_data), .ks_valid(v2), .ks_word(w2)
  );
  hc128_keystream #(.NBANK(4)) u_hc128_keystream_w4 (
    .clk(clk), .rst(rst), .start(start), .load_en(load_en), .load_tsel(load_tsel),
    .load_addr(load_addr), .load_data(load_data), .ks_valid(v4), .ks_word(w4)
  );

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] model_step(int n);
    int i = n % 1024;
    int j = i % 512;
    logic [31:0] x;
    if (i < 512) begin
      mp[j] = mp[j] + ((rr(mp[(j+509)%512], 10) ^ rr(mp[(j+1)%512], 23)) + rr(mp[(j+502)%512], 8));
      x = mp[(j+500)%512];
      return (mq[x[7:0]] + mq[256 + x[23:16]]) ^ mp[j];
    end else begin
      mq[j] = mq[j] + ((rl(mq[(j+509)%512], 10) ^ rl(mq[(j+1)%512], 23)) + rl(mq[(j+502)%512], 8));
      x = mq[(j+500)%512];
      return (mp[x[7:0]] + mp[256 + x[23:16]]) ^ mq[j];
    end
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R2: tables enter only through the load port; the stream checks prove them
  task automatic load_all();
    for (int t = 0; t < 2; t++) begin
      for (int a = 0; a < 512; a++) begin
        @(negedge clk);
        load_en   = 1'b1;
        load_tsel = t[0];
        load_addr = a[8:0];
        load_data = (t == 0) ? mp[a] : mq[a];
      end
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(v2 == 1'b0 && w2 == 32'd0, "R1 valid/word after reset", {31'd0, v2}, 32'd0);
    chk(v4 == 1'b0 && w4 == 32'd0, "R1 valid/word after reset w4", w4, 32'd0);
    rst = 1'b0;
  endtask

  task automatic run_stream(input int nsteps, input int restart_at);
    logic [31:0] e;
    string tag;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(v2 == 1'b0, "R3 valid one edge after start", {31'd0, v2}, 32'd0);
    @(negedge clk);
    chk(v2 == 1'b0, "R3 valid two edges after start", {31'd0, v2}, 32'd0);
    @(negedge clk);
    chk(v2 == 1'b0, "R3 valid three edges... (edge 2)", {31'd0, v2}, 32'd0);
    @(negedge clk);
    chk(v2 == 1'b1 && v4 == 1'b1, "R3 valid on third edge after start", {31'd0, v2}, 32'd1);
    for (int n = 0; n < nsteps; n++) begin
      if (n > 0) @(negedge clk);
      start = (n == restart_at);
      e = model_step(n);
      if (n % 1024 < 512) tag = (n >= 1024) ? "R7 word after wrap" : "R5 P-phase word";
      else tag = "R6 Q-phase word";
      if (n > restart_at && restart_at >= 0) tag = {tag, " (R9 after mid-run start)"};
      chk(w2 == e, tag, w2, e);
      chk(v2 == 1'b1, "R4 valid held", {31'd0, v2}, 32'd1);
      chk(w4 == w2, "R8 four-bank stream equals two-bank", w4, w2);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; load_en = 1'b0; load_tsel = 1'b0;
    load_addr = '0; load_data = '0;
    void'($urandom(32'h1c5e_0a17));
    repeat (3) @(negedge clk);
    chk(v2 == 1'b0 && w2 == 32'd0, "R1 reset state", w2, 32'd0);
    rst = 1'b0;

    // random tables, crossing both phase boundaries, restart pulse mid-run
    for (int a = 0; a < 512; a++) begin
      mp[a] = $urandom();
      mq[a] = $urandom();
    end
    load_all();
    run_stream(1100, 700);

    // directed patterns: dense ones in P, sparse lookup-steering words in Q
    do_reset();
    for (int a = 0; a < 512; a++) begin
      mp[a] = 32'hFFFF_FFFF ^ 32'(a);
      mq[a] = (32'(a) << 23) | 32'(a);
    end
    load_all();
    run_stream(600, -1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule